// File: doc/BRIEF.md
# Control-Port Command Sequencer

This block drives single commands into the control port of a processor core and decides whether each one finished correctly. A caller hands it a command class, a function code, a register number, write data and what it expects back: optionally a read value under a don't-care mask, and flags saying that a command error or a memory error should be reported. The sequencer raises the port request for one cycle and then watches the registered port status for the completion condition of that class. It gives up after a per-class cycle limit.

When a command completes, the sequencer gives a verdict of pass or fail and the number of cycles it waited. When the limit runs out instead, it reports a timeout, pulses the port reset once and holds off new commands for a fixed recovery gap. The three limits start at fixed defaults and can be rewritten while the block runs.

Top module: `cp_cmd_sequencer`

## Requirements
- R1: A command is accepted in a cycle where `ready_o` and `cmd_valid_i` are both high. In the next cycle (the request cycle), `port_req_o` is high for exactly that one cycle, with the accepted function code, register number and write data on `port_func_o`, `port_reg_o` and `port_wdata_o`. `cmd_kind_i` selects the class: 0 ordinary, 1 step, 2 wait-for-halt, 3 behaves as ordinary. The wait-for-halt class never raises `port_req_o`.
- R2: An ordinary command completes on `port_ack_i` high. Its timeout limit after reset is 50.
- R3: A step command completes when `port_busy_i` is low and `port_step_i` is low. Its timeout limit after reset is 100.
- R4: A wait-for-halt operation completes when `port_busy_i` is low and `port_run_i` is low. Its timeout limit after reset is 5000.
- R5: Cycle k counts from the request cycle, which is cycle 0. Port status in cycle 0 is disregarded. If the completion condition first holds in cycle k (k ≥ 1, k ≤ limit), then `done_o` is high in cycle k+2 and `cycles_o` reads k.
- R6: The verdict uses the error and data inputs sampled in the completing cycle. First, if `port_cerr_i` or `exp_cerr_i` is set, the result is pass when they agree and fail otherwise. Failing that, the same rule applies to `port_merr_i` against `exp_merr_i`. Failing that, the data check decides, and with no check enabled the result is pass.
- R7: With `chk_en_i` set, the data check passes exactly when ((`port_rdata_i` XOR `chk_exp_i`) AND NOT `chk_mask_i`) is zero, so a mask bit of 1 marks a don't-care bit.
- R8: If the condition does not hold in any of cycles 1..T, where T is the class limit, then `done_o` is high in cycle T+2 with result timeout and `cycles_o` = T. `port_reset_o` is high in that same cycle only. `ready_o` stays low in that cycle and the nine cycles after it.
- R9: A cycle with `tmo_wr_i` high loads `tmo_val_i` into the limit picked by `tmo_sel_i` (0 ordinary, 1 step, 2 wait-for-halt; 3 writes nothing). Commands accepted later use the new limit.
- R10: `result_o` is encoded 1 pass, 2 fail, 3 timeout. `done_o` is a one-cycle pulse. `result_o` and `cycles_o` hold until the next `done_o`. After reset, `ready_o` = 1, `done_o`, `port_req_o` and `port_reset_o` are 0, and `result_o` and `cycles_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_kind_i | input | 2 | Command class |
| cmd_func_i | input | 5 | Function code for the port |
| cmd_reg_i | input | 3 | Register number for the port |
| cmd_wdata_i | input | 16 | Write data for the port |
| chk_en_i | input | 1 | Enable the read data check |
| chk_exp_i | input | 16 | Expected read value |
| chk_mask_i | input | 16 | Don't-care mask, 1 = ignore bit |
| exp_cerr_i | input | 1 | A command error is expected |
| exp_merr_i | input | 1 | A memory error is expected |
| tmo_wr_i | input | 1 | Write a timeout limit |
| tmo_sel_i | input | 2 | Which limit to write |
| tmo_val_i | input | 16 | New limit value |
| ready_o | output | 1 | Able to accept a command |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Outcome code |
| cycles_o | output | 16 | Cycles waited for the last command |
| port_req_o | output | 1 | Request to the port |
| port_func_o | output | 5 | Function code to the port |
| port_reg_o | output | 3 | Register number to the port |
| port_wdata_o | output | 16 | Write data to the port |
| port_reset_o | output | 1 | Reset pulse to the port after a timeout |
| port_ack_i | input | 1 | Port acknowledge |
| port_busy_i | input | 1 | Port busy |
| port_step_i | input | 1 | Port single-step in progress |
| port_run_i | input | 1 | Core running |
| port_cerr_i | input | 1 | Port command error |
| port_merr_i | input | 1 | Port memory error |
| port_rdata_i | input | 16 | Port read data |

## Verification
Completion and limit expiry are judged in the same evaluation cycle. When the completion condition first holds in exactly cycle T, the waiting stage must give a verdict rather than a timeout. One cycle later, it must time out. The bench drives the completion status in cycle T and in cycle T+1 for the same limit. It expects a verdict with `cycles_o` = T in the first case, and a timeout with the reset pulse and the ten-cycle lockout in the second. Random commands against a short limit revisit this edge many times.

// File: rtl/cp_seq_pkg.sv
package cp_seq_pkg;
  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_STEP  = 2'd1,
    KIND_HALT  = 2'd2,
    KIND_ALT   = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_PASS = 2'd1,
    RES_FAIL = 2'd2,
    RES_TMO  = 2'd3
  } result_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESET, ST_GAP
  } seq_state_e;

  typedef struct packed {
    logic ack;
    logic busy;
    logic step;
    logic run;
    logic cerr;
    logic merr;
  } port_stat_t;
endpackage

// File: rtl/cp_seq_tmo_bank.sv
module cp_seq_tmo_bank
  import cp_seq_pkg::*;
#(
  parameter int unsigned TW       = 16,
  parameter int unsigned DEF_PLN  = 50,
  parameter int unsigned DEF_STP  = 100,
  parameter int unsigned DEF_HLT  = 5000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    sel_i,
  input  logic [TW-1:0] val_i,
  input  cmd_kind_e     kind_i,
  output logic [TW-1:0] limit_o
);
  localparam int unsigned NCLS = 3;
  localparam logic [TW-1:0] DEFS [NCLS] = '{TW'(DEF_PLN), TW'(DEF_STP), TW'(DEF_HLT)};

  logic [TW-1:0] lim_q [NCLS];

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lim_q[g] <= DEFS[g];
      else if (wr_i && sel_i == 2'(g)) lim_q[g] <= val_i;
    end
  end

  always_comb begin
    unique case (kind_i)
      KIND_STEP: limit_o = lim_q[1];
      KIND_HALT: limit_o = lim_q[2];
      default:   limit_o = lim_q[0];
    endcase
  end
endmodule

// File: rtl/cp_seq_sampler.sv
module cp_seq_sampler
  import cp_seq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  port_stat_t    stat_i,
  input  logic [DW-1:0] rdata_i,
  output port_stat_t    stat_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o  <= '0;
      rdata_o <= '0;
    end else begin
      stat_o  <= stat_i;
      rdata_o <= rdata_i;
    end
  end
endmodule

// File: rtl/cp_seq_judge.sv
module cp_seq_judge
  import cp_seq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  cmd_kind_e     kind_i,
  input  port_stat_t    stat_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          chk_en_i,
  input  logic [DW-1:0] chk_exp_i,
  input  logic [DW-1:0] chk_mask_i,
  input  logic          exp_cerr_i,
  input  logic          exp_merr_i,
  output logic          complete_o,
  output logic          pass_o
);
  logic data_ok;
  assign data_ok = ((rdata_i ^ chk_exp_i) & ~chk_mask_i) == '0;

  always_comb begin
    unique case (kind_i)
      KIND_STEP: complete_o = !stat_i.busy && !stat_i.step;
      KIND_HALT: complete_o = !stat_i.busy && !stat_i.run;
      default:   complete_o = stat_i.ack;
    endcase
  end

  // error flags outrank the data check, command error first
  always_comb begin
    if (stat_i.cerr || exp_cerr_i)      pass_o = stat_i.cerr == exp_cerr_i;
    else if (stat_i.merr || exp_merr_i) pass_o = stat_i.merr == exp_merr_i;
    else if (chk_en_i)                  pass_o = data_ok;
    else                                pass_o = 1'b1;
  end
endmodule

// File: rtl/cp_cmd_sequencer.sv
module cp_cmd_sequencer
  import cp_seq_pkg::*;
#(
  parameter int unsigned FW      = 5,
  parameter int unsigned RW      = 3,
  parameter int unsigned DW      = 16,
  parameter int unsigned TW      = 16,
  parameter int unsigned DEF_PLN = 50,
  parameter int unsigned DEF_STP = 100,
  parameter int unsigned DEF_HLT = 5000,
  parameter int unsigned GAP_LEN = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_kind_i,
  input  logic [FW-1:0] cmd_func_i,
  input  logic [RW-1:0] cmd_reg_i,
  input  logic [DW-1:0] cmd_wdata_i,
  input  logic          chk_en_i,
  input  logic [DW-1:0] chk_exp_i,
  input  logic [DW-1:0] chk_mask_i,
  input  logic          exp_cerr_i,
  input  logic          exp_merr_i,
  input  logic          tmo_wr_i,
  input  logic [1:0]    tmo_sel_i,
  input  logic [TW-1:0] tmo_val_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [1:0]    result_o,
  output logic [TW-1:0] cycles_o,
  output logic          port_req_o,
  output logic [FW-1:0] port_func_o,
  output logic [RW-1:0] port_reg_o,
  output logic [DW-1:0] port_wdata_o,
  output logic          port_reset_o,
  input  logic          port_ack_i,
  input  logic          port_busy_i,
  input  logic          port_step_i,
  input  logic          port_run_i,
  input  logic          port_cerr_i,
  input  logic          port_merr_i,
  input  logic [DW-1:0] port_rdata_i
);
  localparam int unsigned GW = $clog2(GAP_LEN + 1);

  seq_state_e    state_q;
  cmd_kind_e     kind_q;
  logic [FW-1:0] func_q;
  logic [RW-1:0] reg_q;
  logic [DW-1:0] wdata_q, exp_q, mask_q;
  logic          chk_q, ecerr_q, emerr_q;
  logic [TW-1:0] cnt_q, cyc_q, limit;
  logic [GW-1:0] gap_q;
  logic          done_q;
  result_e       res_q;

  port_stat_t    stat_raw, stat_s;
  logic [DW-1:0] rdata_s;
  logic          complete, pass;

  assign stat_raw = '{ack: port_ack_i, busy: port_busy_i, step: port_step_i,
                      run: port_run_i, cerr: port_cerr_i, merr: port_merr_i};

  cp_seq_tmo_bank #(.TW(TW), .DEF_PLN(DEF_PLN), .DEF_STP(DEF_STP), .DEF_HLT(DEF_HLT)) i_tmo (
    .clk_i, .rst_ni, .wr_i(tmo_wr_i), .sel_i(tmo_sel_i), .val_i(tmo_val_i),
    .kind_i(kind_q), .limit_o(limit)
  );

  cp_seq_sampler #(.DW(DW)) i_smp (
    .clk_i, .rst_ni, .stat_i(stat_raw), .rdata_i(port_rdata_i),
    .stat_o(stat_s), .rdata_o(rdata_s)
  );

  cp_seq_judge #(.DW(DW)) i_judge (
    .kind_i(kind_q), .stat_i(stat_s), .rdata_i(rdata_s), .chk_en_i(chk_q),
    .chk_exp_i(exp_q), .chk_mask_i(mask_q), .exp_cerr_i(ecerr_q),
    .exp_merr_i(emerr_q), .complete_o(complete), .pass_o(pass)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_PLAIN;
      func_q  <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
      exp_q   <= '0;
      mask_q  <= '0;
      chk_q   <= 1'b0;
      ecerr_q <= 1'b0;
      emerr_q <= 1'b0;
      cnt_q   <= '0;
      cyc_q   <= '0;
      gap_q   <= '0;
      done_q  <= 1'b0;
      res_q   <= RES_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          kind_q  <= cmd_kind_e'(cmd_kind_i);
          func_q  <= cmd_func_i;
          reg_q   <= cmd_reg_i;
          wdata_q <= cmd_wdata_i;
          chk_q   <= chk_en_i;
          exp_q   <= chk_exp_i;
          mask_q  <= chk_mask_i;
          ecerr_q <= exp_cerr_i;
          emerr_q <= exp_merr_i;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          cnt_q   <= '0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          // cnt_q==0 holds the stale sample of the request cycle
          if (cnt_q != '0 && complete) begin
            done_q  <= 1'b1;
            res_q   <= pass ? RES_PASS : RES_FAIL;
            cyc_q   <= cnt_q;
            state_q <= ST_IDLE;
          end else if (cnt_q != '0 && cnt_q >= limit) begin
            done_q  <= 1'b1;
            res_q   <= RES_TMO;
            cyc_q   <= cnt_q;
            state_q <= ST_RESET;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RESET: begin
          gap_q   <= '0;
          state_q <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_q == GW'(GAP_LEN - 1)) state_q <= ST_IDLE;
          else gap_q <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o      = state_q == ST_IDLE;
  assign port_req_o   = state_q == ST_ISSUE && kind_q != KIND_HALT;
  assign port_reset_o = state_q == ST_RESET;
  assign port_func_o  = func_q;
  assign port_reg_o   = reg_q;
  assign port_wdata_o = wdata_q;
  assign done_o       = done_q;
  assign result_o     = res_q;
  assign cycles_o     = cyc_q;

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_req_o |=> !port_req_o); // R1
  AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_req_o |-> $past(ready_o && cmd_valid_i)); // R1
  AST_CYCLES_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cycles_o != '0); // R5
  AST_RESET_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_reset_o |=> !port_reset_o); // R8
  AST_RESET_ON_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_reset_o |-> done_o && result_o == 2'd3); // R8
  AST_LOCKOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_reset_o |-> !ready_o ##1 !ready_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o) && $stable(cycles_o)); // R10
endmodule

// File: tb/test_cp_cmd_sequencer.sv
module test_cp_cmd_sequencer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 0;
  logic [1:0]  cmd_kind_i = 0;
  logic [4:0]  cmd_func_i = 0;
  logic [2:0]  cmd_reg_i = 0;
  logic [15:0] cmd_wdata_i = 0, chk_exp_i = 0, chk_mask_i = 0;
  logic        chk_en_i = 0, exp_cerr_i = 0, exp_merr_i = 0;
  logic        tmo_wr_i = 0;
  logic [1:0]  tmo_sel_i = 0;
  logic [15:0] tmo_val_i = 0;
  logic        ready_o, done_o, port_req_o, port_reset_o;
  logic [1:0]  result_o;
  logic [15:0] cycles_o, port_wdata_o;
  logic [4:0]  port_func_o;
  logic [2:0]  port_reg_o;
  logic        port_ack_i = 0, port_busy_i = 0, port_step_i = 0, port_run_i = 0;
  logic        port_cerr_i = 0, port_merr_i = 0;
  logic [15:0] port_rdata_i = 0;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  cp_cmd_sequencer i_cp_cmd_sequencer (
    .clk_i(clk), .rst_ni, .cmd_valid_i, .cmd_kind_i, .cmd_func_i, .cmd_reg_i,
    .cmd_wdata_i, .chk_en_i, .chk_exp_i, .chk_mask_i, .exp_cerr_i, .exp_merr_i,
    .tmo_wr_i, .tmo_sel_i, .tmo_val_i, .ready_o, .done_o, .result_o, .cycles_o,
    .port_req_o, .port_func_o, .port_reg_o, .port_wdata_o, .port_reset_o,
    .port_ack_i, .port_busy_i, .port_step_i, .port_run_i, .port_cerr_i,
    .port_merr_i, .port_rdata_i
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] verdict(bit ce, bit me, bit ece, bit eme, bit chk,
                                         logic [15:0] rd, logic [15:0] ex, logic [15:0] mk);
    if (ce || ece) return (ce == ece) ? 2'd1 : 2'd2;
    if (me || eme) return (me == eme) ? 2'd1 : 2'd2;
    if (chk && (((rd ^ ex) & ~mk) != 16'd0)) return 2'd2;
    return 2'd1;
  endfunction

  task automatic idle_stat(input int kind, input logic [15:0] junk);
    port_ack_i = 0; port_cerr_i = 0; port_merr_i = 0; port_rdata_i = junk;
    port_busy_i = (kind == 1); port_step_i = (kind == 1); port_run_i = (kind == 2);
  endtask

  task automatic done_stat(input int kind, input bit ce, input bit me, input logic [15:0] rd);
    port_ack_i = (kind != 1 && kind != 2); port_busy_i = 0; port_step_i = 0;
    port_run_i = 0; port_cerr_i = ce; port_merr_i = me; port_rdata_i = rd;
  endtask

  task automatic set_tmo(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    tmo_wr_i = 1; tmo_sel_i = sel; tmo_val_i = val;
    @(negedge clk);
    tmo_wr_i = 0;
  endtask

  // lat = cycle (>=1) with completion status, 0 = never; stale0 shows it in the request cycle
  task automatic run_cmd(input int kind, input int lat, input bit stale0, input int tmo,
                         input bit ce, input bit me, input bit ece, input bit eme,
                         input bit chk, input logic [15:0] rd, input logic [15:0] ex,
                         input logic [15:0] mk);
    logic [4:0]  f = 5'($urandom);
    logic [2:0]  r = 3'($urandom);
    logic [15:0] w = 16'($urandom);
    int done_at = 0;
    bit to;
    @(negedge clk);
    check(ready_o === 1'b1, "R1 ready before accept", ready_o, 1);
    cmd_valid_i = 1; cmd_kind_i = 2'(kind); cmd_func_i = f; cmd_reg_i = r; cmd_wdata_i = w;
    chk_en_i = chk; chk_exp_i = ex; chk_mask_i = mk; exp_cerr_i = ece; exp_merr_i = eme;
    idle_stat(kind, ~rd);
    @(negedge clk);
    cmd_valid_i = 0;
    check(port_req_o === (kind != 2), "R1 request cycle", port_req_o, kind != 2);
    if (kind != 2)
      check(port_func_o == f && port_reg_o == r && port_wdata_o == w, "R1 request fields",
            {port_func_o, port_reg_o, port_wdata_o}, {f, r, w});
    if (stale0) done_stat(kind, ce, me, rd);
    for (int i = 1; i <= tmo + 4 && done_at == 0; i++) begin
      @(negedge clk);
      if (i == 1 && kind != 2) check(port_req_o === 1'b0, "R1 request one cycle", port_req_o, 0);
      if (done_o) done_at = i;
      if (i == lat) done_stat(kind, ce, me, rd);
      else idle_stat(kind, ~rd);
    end
    to = (lat == 0 || lat > tmo);
    if (!to) begin
      check(done_at == lat + 2, "R5 done timing", done_at, lat + 2);
      check(cycles_o == 16'(lat), "R5 cycle count", cycles_o, lat);
      check(result_o == verdict(ce, me, ece, eme, chk, rd, ex, mk), "R6/R7 verdict",
            result_o, verdict(ce, me, ece, eme, chk, rd, ex, mk));
      check(port_reset_o === 1'b0 && ready_o === 1'b1, "R10 idle after verdict",
            {port_reset_o, ready_o}, 1);
    end else begin
      int k = 0;
      check(done_at == tmo + 2, "R8 timeout timing", done_at, tmo + 2);
      check(result_o == 2'd3 && cycles_o == 16'(tmo), "R8 timeout code and count",
            {result_o, cycles_o}, {2'd3, 16'(tmo)});
      check(port_reset_o === 1'b1, "R8 reset with timeout", port_reset_o, 1);
      while (!ready_o && k < 20) begin
        @(negedge clk);
        k++;
        if (k == 1) check(port_reset_o === 1'b0 && done_o === 1'b0, "R8 reset one cycle",
                          {port_reset_o, done_o}, 0);
      end
      check(k == 10, "R8 lockout length", k, 10);
    end
    idle_stat(0, 16'd0); port_busy_i = 0; port_run_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(ready_o === 1'b1 && done_o === 1'b0 && port_req_o === 1'b0 && port_reset_o === 1'b0,
          "R10 reset outputs", {ready_o, done_o, port_req_o, port_reset_o}, 4'b1000);
    check(result_o == 2'd0 && cycles_o == 16'd0, "R10 reset result", {result_o, cycles_o}, 0);
    rst_ni = 1;

    // R2 ordinary, R1 alias kind 3, R3 step, R4 halt completions
    run_cmd(0, 1, 0, 50, 0, 0, 0, 0, 0, 16'h0, 16'h0, 16'h0);
    run_cmd(3, 4, 0, 50, 0, 0, 0, 0, 0, 16'h0, 16'h0, 16'h0);
    run_cmd(1, 7, 0, 100, 0, 0, 0, 0, 0, 16'h0, 16'h0, 16'h0);
    run_cmd(2, 12, 0, 5000, 0, 0, 0, 0, 0, 16'h0, 16'h0, 16'h0);
    // R2/R3/R4 default limits
    run_cmd(0, 0, 0, 50, 0, 0, 0, 0, 0, 16'h0, 16'h0, 16'h0);
    run_cmd(1, 0, 0, 100, 0, 0, 0, 0, 0, 16'h0, 16'h0, 16'h0);
    run_cmd(2, 0, 0, 5000, 0, 0, 0, 0, 0, 16'h0, 16'h0, 16'h0);
    // R5/R8 boundary: last allowed cycle vs one late
    run_cmd(0, 50, 0, 50, 0, 0, 0, 0, 0, 16'h0, 16'h0, 16'h0);
    run_cmd(0, 51, 0, 50, 0, 0, 0, 0, 0, 16'h0, 16'h0, 16'h0);
    // R9 runtime limit, R5 stale request-cycle status
    set_tmo(2'd0, 16'd4);
    run_cmd(0, 0, 1, 4, 0, 0, 0, 0, 0, 16'h0, 16'h0, 16'h0);
    set_tmo(2'd3, 16'd2);
    run_cmd(0, 4, 0, 4, 0, 0, 0, 0, 0, 16'h0, 16'h0, 16'h0);
    set_tmo(2'd0, 16'd50);
    // R6 priority
    run_cmd(0, 2, 0, 50, 1, 1, 1, 0, 1, 16'h1, 16'h2, 16'h0);
    run_cmd(0, 2, 0, 50, 0, 0, 1, 0, 0, 16'h0, 16'h0, 16'h0);
    run_cmd(0, 2, 0, 50, 0, 1, 0, 0, 0, 16'h0, 16'h0, 16'h0);
    run_cmd(0, 2, 0, 50, 0, 1, 0, 1, 1, 16'h5, 16'h6, 16'h0);
    // R7 mask
    run_cmd(0, 3, 0, 50, 0, 0, 0, 0, 1, 16'h12F0, 16'h1200, 16'h00FF);
    run_cmd(0, 3, 0, 50, 0, 0, 0, 0, 1, 16'h13F0, 16'h1200, 16'h00FF);
    run_cmd(0, 3, 0, 50, 0, 0, 0, 0, 1, 16'hBEEF, 16'hBEEF, 16'h0000);

    // random mix against short limits, R9 applied to every class
    set_tmo(2'd0, 16'd20); set_tmo(2'd1, 16'd20); set_tmo(2'd2, 16'd20);
    for (int n = 0; n < 80; n++) begin
      int lat = ($urandom % 5 == 0) ? 0 : int'($urandom % 24) + 1;
      logic [15:0] rd = 16'($urandom);
      logic [15:0] mk = ($urandom % 2) ? 16'($urandom) : 16'h0;
      logic [15:0] ex = ($urandom % 2) ? rd ^ (16'($urandom) & mk) : 16'($urandom);
      run_cmd(int'($urandom % 4), lat, 0, 20, 1'($urandom % 4 == 0), 1'($urandom % 4 == 0),
              1'($urandom % 4 == 0), 1'($urandom % 4 == 0), 1'($urandom), rd, ex, mk);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule